// File: doc/BRIEF.md
# Element Offset Remap Address Generator

This block turns a vector loop's element index into per-operand register addresses. Each request carries an element index, a base register number for each of five operand slots (three sources, two destinations), an element width and a choice of one of four stored shape words. A shape word holds an unsigned 4-bit element offset and a 5-bit slot enable mask. For every enabled slot the offset is added to the element index before the index is split into a register step and a lane within a 64-bit register. Disabled slots get the plain split. A shifted source, such as "add each byte to the byte before it", then needs no separate slide operation.

Shape words are written by a one-cycle configuration strobe. Requests arrive on a valid/ready stream and results leave on a registered valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being consumed in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its contents and no new request is taken. A negative shift is obtained by using the offset modulo the lanes per register together with a base one register lower. The block holds no loop-length state and changes none.

Top module: `offset_remap_agen`

## Requirements
- R1: After reset `out_valid` is 0 and all four shape words are zero, so every slot gets the unshifted mapping.
- R2: For an enabled slot at 8-bit width (`req_ew`=0), with effective index e = index + offset, the register is base + e/8 and the lane is e mod 8.
- R3: A slot whose mask bit is clear outputs register base + index/L and lane index mod L, where L is the lanes per register.
- R4: `req_ew` values 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements, giving L = 8, 4, 2 and 1. The lane is e mod L and the register step is e/L; with L = 1 the lane is always 0.
- R5: Mask bit 0 enables in0, bit 1 in1, bit 2 in2, bit 3 out0 and bit 4 out1. Slot k occupies bits [7k+6:7k] of `req_base` and `out_reg`, and bits [3k+2:3k] of `out_lane`.
- R6: The offset is an unsigned value from 0 to 15, so at 8-bit width it can shift by up to one register plus seven lanes.
- R7: A strobe on `cfg_we` writes `cfg_mask` and `cfg_offset` into the shape word chosen by `cfg_sel` (0 to 3) and leaves the other three unchanged. `req_shape` chooses the word a request uses. A request accepted on the same edge as a write sees the previous contents.
- R8: The output register number is (base + step) mod 128.
- R9: The addresses for an accepted request appear with `out_valid` high one clock after acceptance. While `out_valid`=1 and `out_ready`=0, the outputs stay stable and `req_ready` is 0.
- R10: When the output is consumed and no request is accepted on that edge, `out_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Shape word write strobe |
| cfg_sel | input | 2 | Shape word to write |
| cfg_mask | input | 5 | Slot enable mask to store |
| cfg_offset | input | 4 | Unsigned element offset to store |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_idx | input | 7 | Element index |
| req_shape | input | 2 | Shape word applied to this request |
| req_ew | input | 2 | Element width code |
| req_base | input | 35 | Five 7-bit base register numbers |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_reg | output | 35 | Five 7-bit register numbers |
| out_lane | output | 15 | Five 3-bit lane numbers |

## Verification
The bench aims at the points where the offset crosses a register boundary, and at offset 15 at byte width, where a design that kept only three offset bits or split the index before adding the offset would report the wrong register. It walks a single enable bit across the mask, which exposes a design that swaps slots or applies the offset to all of them. It checks that 64-bit elements always report lane 0, which a wrong lane mask breaks. It also targets base values near 127, where a design without wraparound gives the wrong register. On the stream side it holds `out_ready` low, which a design that overwrites its output register would fail, and it writes a shape word on the same edge a request uses it, which a design with a write-through path would get wrong.

// File: rtl/offset_remap_pkg.sv
package offset_remap_pkg;
  localparam int NSLOTS   = 5;
  localparam int REG_W    = 7;
  localparam int IDX_W    = 7;
  localparam int OFF_W    = 4;
  localparam int NSHAPES  = 4;
  localparam int SHAPE_W  = 32;
  localparam int LANE_W   = 3;   // log2 of byte lanes in a 64-bit register
  localparam int SEL_W    = $clog2(NSHAPES);

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_width_e;

  // shape word layout: offset in the low bits, slot mask above it
  localparam int OFF_LSB  = 0;
  localparam int MASK_LSB = OFF_W;
endpackage

// File: rtl/orag_shape_bank.sv
module orag_shape_bank
  import offset_remap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [NSLOTS-1:0]  wr_mask,
  input  logic [OFF_W-1:0]   wr_offset,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [SHAPE_W-1:0] rd_word
);
  logic [SHAPE_W-1:0] words [NSHAPES];
  logic [SHAPE_W-1:0] wr_word;

  always_comb begin
    wr_word = '0;
    wr_word[OFF_LSB  +: OFF_W]  = wr_offset;
    wr_word[MASK_LSB +: NSLOTS] = wr_mask;
  end

  for (genvar s = 0; s < NSHAPES; s++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[s] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(s)))
        words[s] <= wr_word;
    end
  end

  assign rd_word = words[rd_sel];
endmodule

// File: rtl/orag_slot_map.sv
module orag_slot_map
  import offset_remap_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  base,
  input  logic              en,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        ew,
  output logic [REG_W-1:0]  reg_num,
  output logic [LANE_W-1:0] lane
);
  localparam int EFF_W = IDX_W + 1;
  localparam logic [1:0] MAX_SH = 2'(LANE_W);

  logic [EFF_W-1:0]  eff;
  logic [EFF_W-1:0]  step;
  logic [1:0]        shamt;
  logic [LANE_W-1:0] lane_mask;

  always_comb begin
    eff       = {1'b0, idx} + (en ? EFF_W'(offset) : '0);
    shamt     = MAX_SH - ew;
    step      = eff >> shamt;
    lane_mask = {LANE_W{1'b1}} >> ew;
    reg_num   = base + step[REG_W-1:0];
    lane      = eff[LANE_W-1:0] & lane_mask;
  end
endmodule

// File: rtl/offset_remap_agen.sv
module offset_remap_agen
  import offset_remap_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [NSLOTS-1:0]        cfg_mask,
  input  logic [OFF_W-1:0]         cfg_offset,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [IDX_W-1:0]         req_idx,
  input  logic [SEL_W-1:0]         req_shape,
  input  logic [1:0]               req_ew,
  input  logic [NSLOTS*REG_W-1:0]  req_base,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NSLOTS*REG_W-1:0]  out_reg,
  output logic [NSLOTS*LANE_W-1:0] out_lane
);
  logic [SHAPE_W-1:0]       shape;
  logic [NSLOTS-1:0]        slot_en;
  logic [OFF_W-1:0]         offset;
  logic [NSLOTS*REG_W-1:0]  nxt_reg;
  logic [NSLOTS*LANE_W-1:0] nxt_lane;
  logic                     take;

  orag_shape_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_sel    (cfg_sel),
    .wr_mask   (cfg_mask),
    .wr_offset (cfg_offset),
    .rd_sel    (req_shape),
    .rd_word   (shape)
  );

  assign offset  = shape[OFF_LSB  +: OFF_W];
  assign slot_en = shape[MASK_LSB +: NSLOTS];

  for (genvar k = 0; k < NSLOTS; k++) begin : g_slot
    orag_slot_map u_map (
      .idx     (req_idx),
      .base    (req_base[k*REG_W +: REG_W]),
      .en      (slot_en[k]),
      .offset  (offset),
      .ew      (req_ew),
      .reg_num (nxt_reg[k*REG_W +: REG_W]),
      .lane    (nxt_lane[k*LANE_W +: LANE_W])
    );
  end

  assign req_ready = !out_valid || out_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_reg   <= '0;
      out_lane  <= '0;
    end else begin
      if (req_ready) out_valid <= req_valid;
      if (take) begin
        out_reg  <= nxt_reg;
        out_lane <= nxt_lane;
      end
    end
  end
endmodule

// File: rtl/orag_checker.sv
module orag_checker
  import offset_remap_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [NSLOTS*REG_W-1:0]  out_reg,
  input logic [NSLOTS*LANE_W-1:0] out_lane
);
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_reg) && $stable(out_lane)); // R9

  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready); // R9

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid); // R9

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !req_valid |=> !out_valid); // R10

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1
endmodule

bind offset_remap_agen orag_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_reg   (out_reg),
  .out_lane  (out_lane)
);

// File: tb/offset_remap_agen_bench.sv
`timescale 1ns/1ps
module offset_remap_agen_bench;
  import offset_remap_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic [NSLOTS-1:0] cfg_mask = '0;
  logic [OFF_W-1:0] cfg_offset = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [IDX_W-1:0] req_idx = '0;
  logic [SEL_W-1:0] req_shape = '0;
  logic [1:0] req_ew = '0;
  logic [NSLOTS*REG_W-1:0] req_base = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NSLOTS*REG_W-1:0] out_reg;
  logic [NSLOTS*LANE_W-1:0] out_lane;

  int tests = 0;
  int fails = 0;
  logic [NSLOTS-1:0] m_mask [NSHAPES];
  logic [OFF_W-1:0]  m_off  [NSHAPES];

  always #5 clk = ~clk;

  offset_remap_agen u_offset_remap_agen (.*);

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic void expect_slot(input int idx, input int base, input bit en,
                                      input int off, input int ew,
                                      output int r, output int l);
    int lanes = 8 >> ew;
    int e = idx + (en ? off : 0);
    r = (base + e / lanes) % 128;
    l = e % lanes;
  endfunction

  task automatic check1(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compute expectations from model config, for shape s
  task automatic check_out(input string req, input int idx, input int s,
                           input int ew, input logic [NSLOTS*REG_W-1:0] bases,
                           input logic [NSLOTS-1:0] mask, input int off);
    int r, l;
    tests++;
    for (int k = 0; k < NSLOTS; k++) begin
      expect_slot(idx, int'(bases[k*REG_W +: REG_W]), mask[k], off, ew, r, l);
      if (out_reg[k*REG_W +: REG_W] != REG_W'(r) ||
          out_lane[k*LANE_W +: LANE_W] != LANE_W'(l) || !out_valid) begin
        fails++;
        $display("FAIL %s slot %0d shape %0d: actual reg %0d lane %0d valid %0b expected reg %0d lane %0d valid 1",
                 req, k, s, out_reg[k*REG_W +: REG_W], out_lane[k*LANE_W +: LANE_W],
                 out_valid, r, l);
        break;
      end
    end
  endtask

  task automatic write_shape(input int s, input logic [NSLOTS-1:0] mask, input int off);
    cfg_we = 1'b1; cfg_sel = SEL_W'(s); cfg_mask = mask; cfg_offset = OFF_W'(off);
    @(negedge clk);
    cfg_we = 1'b0;
    m_mask[s] = mask; m_off[s] = OFF_W'(off);
  endtask

  // present one request, check result one clock later
  task automatic send(input string req, input int idx, input int s, input int ew,
                      input logic [NSLOTS*REG_W-1:0] bases);
    req_valid = 1'b1; req_idx = IDX_W'(idx); req_shape = SEL_W'(s);
    req_ew = 2'(ew); req_base = bases;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(req, idx, s, ew, bases, m_mask[s], int'(m_off[s]));
  endtask

  function automatic logic [NSLOTS*REG_W-1:0] mk_bases(input int b0, input int b1,
      input int b2, input int b3, input int b4);
    return {REG_W'(b4), REG_W'(b3), REG_W'(b2), REG_W'(b1), REG_W'(b0)};
  endfunction

  task automatic t_reset();
    check1("R1 out_valid after reset", int'(out_valid), 0);
    // shape words zero: idx 9 at bytes -> base+1, lane 1 in every slot
    send("R1 zero shape", 9, 2, 0, mk_bases(10, 20, 30, 40, 50));
    check1("R1 slot0 reg", int'(out_reg[6:0]), 11);
  endtask

  task automatic t_offset_bytes();
    write_shape(0, 5'b11111, 1);
    for (int i = 0; i < 10; i++)
      send("R2 byte offset 1", i * 3, 0, 0, mk_bases(64, 32, 8, 1, 100));
    // idx 7 + 1 -> next register lane 0
    send("R2 boundary", 7, 0, 0, mk_bases(64, 64, 64, 64, 64));
    check1("R2 crossing reg", int'(out_reg[6:0]), 65);
    check1("R2 crossing lane", int'(out_lane[2:0]), 0);
  endtask

  task automatic t_disabled();
    write_shape(1, 5'b00000, 9);
    for (int i = 0; i < 6; i++)
      send("R3 unshifted", i * 5 + 1, 1, i % 4, mk_bases(3, 9, 27, 81, 120));
  endtask

  task automatic t_widths();
    write_shape(2, 5'b10101, 3);
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 6; i++)
        send("R4 width", i * 7, 2, w, mk_bases(16, 17, 18, 19, 20));
    send("R4 64-bit", 12, 2, 3, mk_bases(0, 0, 0, 0, 0));
    check1("R4 64-bit lane zero", int'(out_lane[2:0]), 0);
    check1("R4 64-bit reg", int'(out_reg[6:0]), 15);
  endtask

  task automatic t_mask_order();
    for (int k = 0; k < NSLOTS; k++) begin
      write_shape(3, NSLOTS'(1 << k), 2);
      send("R5 single slot", 6, 3, 0, mk_bases(40, 40, 40, 40, 40));
      // only slot k shifted: reg 41 lane 0; others reg 40 lane 6
      check1("R5 enabled slot reg", int'(out_reg[k*REG_W +: REG_W]), 41);
      check1("R5 other slot lane", int'(out_lane[((k + 1) % NSLOTS)*LANE_W +: LANE_W]), 6);
    end
  endtask

  task automatic t_offset15();
    write_shape(0, 5'b01000, 15);
    send("R6 offset 15", 7, 0, 0, mk_bases(0, 0, 0, 50, 0));
    check1("R6 reg two over", int'(out_reg[3*REG_W +: REG_W]), 52);
    check1("R6 lane", int'(out_lane[3*LANE_W +: LANE_W]), 6);
  endtask

  task automatic t_select();
    write_shape(1, 5'b00001, 4);
    write_shape(2, 5'b00001, 8);
    send("R7 shape1", 2, 1, 0, mk_bases(10, 0, 0, 0, 0));
    check1("R7 shape1 lane", int'(out_lane[2:0]), 6);
    send("R7 shape2", 2, 2, 0, mk_bases(10, 0, 0, 0, 0));
    check1("R7 shape2 reg", int'(out_reg[6:0]), 11);
    // write and use on same edge: old offset 4 applies
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_mask = 5'b00001; cfg_offset = 4'd12;
    req_valid = 1'b1; req_idx = 7'd2; req_shape = 2'd1; req_ew = 2'd0;
    req_base = mk_bases(10, 0, 0, 0, 0);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check1("R7 same edge old value lane", int'(out_lane[2:0]), 6);
    m_mask[1] = 5'b00001; m_off[1] = 4'd12;
    send("R7 new value", 2, 1, 0, mk_bases(10, 0, 0, 0, 0));
    check1("R7 new value reg", int'(out_reg[6:0]), 11);
  endtask

  task automatic t_wrap();
    write_shape(0, 5'b11111, 15);
    send("R8 wrap", 127, 0, 0, mk_bases(127, 126, 120, 110, 100));
    // 127+15=142 -> step 17; 127+17=144 -> 16
    check1("R8 wrapped reg", int'(out_reg[6:0]), 16);
    send("R8 wrap 64-bit", 100, 0, 3, mk_bases(127, 126, 120, 110, 100));
  endtask

  task automatic t_stream();
    logic [NSLOTS*REG_W-1:0] held;
    write_shape(3, 5'b00011, 1);
    out_ready = 1'b0;
    send("R9 one cycle latency", 5, 3, 0, mk_bases(8, 8, 8, 8, 8));
    held = out_reg;
    req_valid = 1'b1; req_idx = 7'd30; req_shape = 2'd3; req_ew = 2'd1;
    req_base = mk_bases(1, 2, 3, 4, 5);
    for (int c = 0; c < 3; c++) begin
      check1("R9 ready low while stalled", int'(req_ready), 0);
      @(negedge clk);
      check1("R9 output held", int'(out_reg == held && out_valid), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R9 pending request after release", 30, 3, 1,
              mk_bases(1, 2, 3, 4, 5), m_mask[3], int'(m_off[3]));
    @(negedge clk);
    check1("R10 drained", int'(out_valid), 0);
  endtask

  initial begin
    for (int s = 0; s < NSHAPES; s++) begin m_mask[s] = '0; m_off[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_offset_bytes();
    t_disabled();
    t_widths();
    t_mask_order();
    t_offset15();
    t_select();
    t_wrap();
    t_stream();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule